// File: doc/BRIEF.md
# Timer Capture-Compare-PWM Channel

This block is a single channel of a general-purpose timer. It sits beside a shared free-running up-counter, which is built elsewhere and which supplies its count value and a one-cycle overflow strobe. Software configures the channel through a byte-wide register bus. The channel can work in one of three ways:

- **Input capture:** it latches the counter when a chosen edge appears on its pin.
- **Output compare:** it acts on its output pin when the counter reaches a programmed value.
- **Edge-aligned PWM:** it combines compare-match actions with toggling on overflow.

A status flag records each capture or match. An interrupt request follows that flag when the interrupt is enabled.

The channel has one 8-bit control register and a 16-bit value register, which is read and written one byte at a time. In buffered mode the compare value that software writes takes effect only at the next counter overflow. This keeps PWM periods glitch-free. A forced-maximum bit gives 100% duty. Clearing on match while toggling on overflow at the top count gives 0% duty.

Top module: `tmr_ccp_channel`

## Requirements
- R1: After reset every register reads 0, `pin_out`, `pin_oe` and `irq` are 0.
- R2: Control register bits (bit 7 down to 0): flag, interrupt enable, mode[1], mode[0], select[1], select[0], toggle-on-overflow, force-max. Bits 6..0 are read/write. Writing bit 7 as 0 clears the flag and writing it as 1 leaves the flag unchanged. A flag-setting event in the same cycle as a clear wins.
- R3: `irq` is 1 exactly when both the flag and the interrupt enable are 1.
- R4: In capture mode (mode = 00) the pin passes two synchronizer flops. The flag sets and the value register loads the counter on the third rising clock edge after the pin changes. A capture overrides a bus write in the same cycle.
- R5: In capture mode, select = 01 captures rising edges, 10 captures falling edges, 11 captures both, and 00 captures nothing.
- R6: In output modes (mode != 00) the flag sets on each cycle where the counter equals the effective compare value.
- R7: On a match in an output mode, select = 01 toggles the output, 10 drives it low, 11 drives it high, and 00 leaves it alone. `pin_oe` is 1 only in an output mode with select != 00.
- R8: With toggle-on-overflow set in an enabled output mode, the output toggles on each overflow strobe.
- R9: When a match and an overflow toggle fall in the same cycle, only the match action is applied.
- R10: With force-max set in an enabled output mode, `pin_out` is 1 regardless of the internal output state.
- R11: Mode 01 compares against the value register directly. Mode 1x compares against a copy of it that is reloaded at each overflow strobe.
- R12: Bus address 0 is the control register, 1 the value high byte, 2 the value low byte, and 3 reads as 0. Read data is combinational from `bus_addr`. Writes take effect on the clock edge where `bus_sel` and `bus_we` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_val | input | CNT_W | Shared counter value |
| cnt_ovf | input | 1 | One-cycle counter overflow strobe |
| bus_sel | input | 1 | Bus access select |
| bus_we | input | 1 | Bus write enable |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| pin_in | input | 1 | Channel pin, capture input |
| pin_out | output | 1 | Channel pin, compare/PWM output |
| pin_oe | output | 1 | Output enable for the channel pin |
| irq | output | 1 | Interrupt request |

## Verification
A wrong synchronizer depth or a wrong edge decode shows up directly on the flag bit. The flag then sets one cycle early or late, or on the wrong edge polarity, and the value register holds a wrong counter value; both are visible on the first read after the pin change. A corrupted output register or a wrong action priority shows on `pin_out` within one counter period, as a changed duty or a duty stuck away from 0% or 100%. A compare buffer that loads at the wrong time shows as a flag that sets in the period before the next overflow instead of after it.

// File: rtl/ccp_pkg.sv
`timescale 1ns/1ps
// Package: shared types and encodings of the capture-compare-PWM channel.
// Assumes the control register is exactly eight bits wide.
package ccp_pkg;

    // Control register, bit 7 first.
    typedef struct packed {
        logic       flag;   // event flag, write 0 to clear
        logic       ie;     // interrupt enable
        logic [1:0] mode;   // 00 capture, 01 compare, 1x buffered compare
        logic [1:0] sel;    // edge or output action select
        logic       tov;    // toggle on overflow
        logic       maxd;   // force output high (100% duty)
    } ccp_ctl_t;

    localparam logic [1:0] MODE_CAPTURE = 2'b00;
    localparam logic [1:0] SEL_OFF      = 2'b00;
    localparam logic [1:0] SEL_TOGGLE   = 2'b01;
    localparam logic [1:0] SEL_LOW      = 2'b10;
    localparam logic [1:0] SEL_HIGH     = 2'b11;

endpackage

// File: rtl/ccp_edge_det.sv
`timescale 1ns/1ps
// Module: ccp_edge_det
// Brings an asynchronous pin into the clock domain through a flop chain and
// reports one-cycle rising and falling edge pulses of the synchronized level.
// Assumes SYNC_STAGES >= 2. All flops reset to 0.
module ccp_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic rise,
    output logic fall
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] sync_q;
    logic         last_q;

    // Shift the pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[TOP-1:0], pin_in};
    end

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[TOP];
    end

    // Edge pulses from the current and previous synchronized levels.
    always_comb begin
        rise = sync_q[TOP] & ~last_q;
        fall = ~sync_q[TOP] & last_q;
    end

endmodule

// File: rtl/ccp_regs.sv
`timescale 1ns/1ps
// Module: ccp_regs
// Holds the control register, the channel value register (byte-addressed,
// high byte first) and the overflow-loaded compare buffer; serves bus reads.
// Assumes CNT_W is a multiple of 8 and 1 + CNT_W/8 addresses fit in ADDR_W.
module ccp_regs
    import ccp_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              cap_load,
    input  logic              flag_set,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              cnt_ovf,
    output ccp_ctl_t          ctl,
    output logic [CNT_W-1:0]  chan_val,
    output logic [CNT_W-1:0]  cmp_val,
    output logic [7:0]        bus_rdata
);
    localparam int NBYTES = CNT_W / 8;

    ccp_ctl_t         ctl_q;
    logic             wr_ctl;
    logic             flag_nxt;
    logic [CNT_W-1:0] buf_q;

    // Decode a write to the control register.
    assign wr_ctl = bus_sel & bus_we & (bus_addr == '0);

    // Flag: set event wins over a write-0 clear; write-1 keeps it.
    always_comb begin
        flag_nxt = ctl_q.flag;
        if (wr_ctl && !bus_wdata[7]) flag_nxt = 1'b0;
        if (flag_set)                flag_nxt = 1'b1;
    end

    // Control register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q.flag <= flag_nxt;
            if (wr_ctl)
                {ctl_q.ie, ctl_q.mode, ctl_q.sel, ctl_q.tov, ctl_q.maxd} <= bus_wdata[6:0];
        end
    end

    // One byte lane of the value register per generate iteration.
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        localparam int LSB = CNT_W - 8 * (b + 1);
        logic       wr_b;
        logic [7:0] byte_q;

        assign wr_b = bus_sel & bus_we & (bus_addr == ADDR_W'(b + 1));

        // Capture has priority over a software write of this byte.
        always_ff @(posedge clk) begin
            if (!rst_n)        byte_q <= '0;
            else if (cap_load) byte_q <= cnt_val[LSB +: 8];
            else if (wr_b)     byte_q <= bus_wdata;
        end

        assign chan_val[LSB +: 8] = byte_q;
    end

    // Compare buffer reloaded from the value register at each overflow.
    always_ff @(posedge clk) begin
        if (!rst_n)       buf_q <= '0;
        else if (cnt_ovf) buf_q <= chan_val;
    end

    // Effective compare value: buffered copy in mode 1x, direct otherwise.
    assign cmp_val = ctl_q.mode[1] ? buf_q : chan_val;
    assign ctl     = ctl_q;

    // Combinational read multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == '0) bus_rdata = ctl_q;
        for (int b = 0; b < NBYTES; b++) begin
            if (bus_addr == ADDR_W'(b + 1))
                bus_rdata = chan_val[CNT_W - 8 * (b + 1) +: 8];
        end
    end

endmodule

// File: rtl/ccp_out_ctl.sv
`timescale 1ns/1ps
// Module: ccp_out_ctl
// Keeps the channel output level: match actions, toggle on overflow (match
// takes priority), and forcing of the pin high for 100% duty.
// Assumes out_en already folds in output mode and a non-zero select.
module ccp_out_ctl
    import ccp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       out_en,
    input  logic [1:0] act,
    input  logic       tov,
    input  logic       maxd,
    input  logic       match,
    input  logic       ovf,
    output logic       pin_out
);
    logic out_q;

    // Output level update; a match action masks the overflow toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else if (out_en) begin
            if (match) begin
                case (act)
                    SEL_TOGGLE: out_q <= ~out_q;
                    SEL_LOW:    out_q <= 1'b0;
                    SEL_HIGH:   out_q <= 1'b1;
                    default:    out_q <= out_q;
                endcase
            end else if (tov && ovf) begin
                out_q <= ~out_q;
            end
        end
    end

    // Force-max overrides the stored level.
    assign pin_out = out_q | (maxd & out_en);

endmodule

// File: rtl/tmr_ccp_channel.sv
`timescale 1ns/1ps
// Module: tmr_ccp_channel (top)
// One timer channel: input capture, output compare or edge-aligned PWM on a
// shared counter. Decodes capture and match events, drives the flag, the
// interrupt request and the pin enable.
// Assumes cnt_ovf is high for one cycle when the counter wraps.
module tmr_ccp_channel
    import ccp_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              cnt_ovf,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              pin_in,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              irq
);
    ccp_ctl_t         ctl_q;
    logic [CNT_W-1:0] chan_val;
    logic [CNT_W-1:0] cmp_val;
    logic             rise, fall;
    logic             cap_evt, match, flag_set;
    logic             out_mode, out_en;

    ccp_edge_det #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_in(pin_in),
        .rise  (rise),
        .fall  (fall)
    );

    // Event decode: capture on selected edges, match on counter equality.
    always_comb begin
        out_mode = (ctl_q.mode != MODE_CAPTURE);
        out_en   = out_mode & (ctl_q.sel != SEL_OFF);
        cap_evt  = ~out_mode & ((ctl_q.sel[0] & rise) | (ctl_q.sel[1] & fall));
        match    = out_mode & (cnt_val == cmp_val);
        flag_set = cap_evt | match;
    end

    ccp_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .cap_load (cap_evt),
        .flag_set (flag_set),
        .cnt_val  (cnt_val),
        .cnt_ovf  (cnt_ovf),
        .ctl      (ctl_q),
        .chan_val (chan_val),
        .cmp_val  (cmp_val),
        .bus_rdata(bus_rdata)
    );

    ccp_out_ctl out_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .out_en (out_en),
        .act    (ctl_q.sel),
        .tov    (ctl_q.tov),
        .maxd   (ctl_q.maxd),
        .match  (match),
        .ovf    (cnt_ovf),
        .pin_out(pin_out)
    );

    // Pin enable and interrupt request.
    assign pin_oe = out_en;
    assign irq    = ctl_q.flag & ctl_q.ie;

endmodule

// File: rtl/ccp_chk.sv
`timescale 1ns/1ps
// Module: ccp_chk
// Assertion checker bound to tmr_ccp_channel.
module ccp_chk #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wdata_msb,
    input logic [CNT_W-1:0]  cnt_val,
    input logic [CNT_W-1:0]  chan_val,
    input logic [7:0]        ctl_byte,
    input logic              cap_evt,
    input logic              flag_set,
    input logic              pin_out,
    input logic              pin_oe,
    input logic              irq
);
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_byte[6] |-> !irq); // R3

    AST_FLAG_WRITE_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl_byte[7]) && $past(bus_sel && bus_we && bus_addr == '0 && wdata_msb))
        |-> ctl_byte[7]); // R2

    AST_FLAG_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_byte[7]) |-> $past(flag_set)); // R6

    AST_CAPTURE_LOADS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cap_evt) |-> chan_val == $past(cnt_val)); // R4

    AST_MAX_FORCES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_byte[5:4] != 2'b00 && ctl_byte[3:2] != 2'b00 && ctl_byte[0]) |-> pin_out); // R10

    AST_CAPTURE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_byte[5:4] == 2'b00) |-> !pin_oe); // R7

endmodule

bind tmr_ccp_channel ccp_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .wdata_msb(bus_wdata[7]),
    .cnt_val  (cnt_val),
    .chan_val (chan_val),
    .ctl_byte (ctl_q),
    .cap_evt  (cap_evt),
    .flag_set (flag_set),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .irq      (irq)
);

// File: tb/tmr_ccp_channel_tb_top.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module tmr_ccp_channel_tb_top;
    localparam int MOD = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt = '0;
    logic        cnt_run = 1'b0;
    logic        cnt_ld = 1'b0;
    logic [15:0] cnt_ld_val = '0;
    logic        cnt_ovf;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        pin_in = 1'b0;
    logic        pin_out, pin_oe, irq;
    int          n_chk = 0;
    int          n_fail = 0;

    always #5 clk = ~clk;

    // Bench counter model: wraps at MOD-1 with an overflow strobe.
    always_ff @(posedge clk) begin
        if (cnt_ld)       cnt <= cnt_ld_val;
        else if (cnt_run) cnt <= (cnt == 16'(MOD - 1)) ? '0 : cnt + 16'd1;
    end
    assign cnt_ovf = cnt_run && (cnt == 16'(MOD - 1));

    tmr_ccp_channel dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt), .cnt_ovf(cnt_ovf),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cnt_run = 1'b0; pin_in = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic load_cnt(input logic [15:0] v, input logic run);
        cnt_ld = 1'b1; cnt_ld_val = v;
        @(negedge clk);
        cnt_ld = 1'b0; cnt_run = run;
    endtask

    task automatic wait_cnt(input logic [15:0] v);
        do @(negedge clk); while (cnt != v);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        do_reset();
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            chk("R1 reg reads 0", d, 0);
        end
        chk("R1 pin_out", pin_out, 0);
        chk("R1 pin_oe", pin_oe, 0);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        do_reset();
        wr(2'd0, 8'h4C);
        rd(2'd0, d); chk("R2 ctl readback", d, 8'h4C);
        wr(2'd1, 8'hAB); wr(2'd2, 8'hCD);
        rd(2'd1, d); chk("R12 value high byte", d, 8'hAB);
        rd(2'd2, d); chk("R12 value low byte", d, 8'hCD);
        rd(2'd3, d); chk("R12 unused address", d, 8'h00);
        pin_in = 1'b1;
        repeat (4) @(negedge clk);
        rd(2'd0, d); chk("R2 flag set by capture", d, 8'hCC);
        chk("R3 irq with enable", irq, 1);
        wr(2'd0, 8'hCC);
        rd(2'd0, d); chk("R2 write 1 keeps flag", d, 8'hCC);
        wr(2'd0, 8'h8C);
        chk("R3 irq masked", irq, 0);
        wr(2'd0, 8'h4C);
        rd(2'd0, d); chk("R2 write 0 clears flag", d, 8'h4C);
        chk("R3 irq after clear", irq, 0);
    endtask

    task automatic t_capture();
        logic [7:0] d, h, l;
        do_reset();
        load_cnt(16'h1234, 1'b0);
        wr(2'd0, 8'h04);
        pin_in = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(2'd0, d); chk("R4 flag not before third edge", d[7], 0);
        @(negedge clk);
        rd(2'd0, d); chk("R4 flag on third edge", d[7], 1);
        rd(2'd1, h); rd(2'd2, l);
        chk("R4 captured value", {h, l}, 16'h1234);
        wr(2'd0, 8'h04);
        load_cnt(16'h5555, 1'b0);
        pin_in = 1'b0;
        repeat (4) @(negedge clk);
        rd(2'd0, d); chk("R5 rising-only ignores fall", d[7], 0);
        rd(2'd1, h); rd(2'd2, l);
        chk("R5 value kept on ignored fall", {h, l}, 16'h1234);
        wr(2'd0, 8'h08);
        pin_in = 1'b1;
        repeat (4) @(negedge clk);
        rd(2'd0, d); chk("R5 falling-only ignores rise", d[7], 0);
        pin_in = 1'b0;
        repeat (4) @(negedge clk);
        rd(2'd0, d); chk("R5 falling edge captured", d[7], 1);
        rd(2'd1, h); rd(2'd2, l);
        chk("R5 falling capture value", {h, l}, 16'h5555);
        wr(2'd0, 8'h0C);
        load_cnt(16'h0777, 1'b0);
        pin_in = 1'b1;
        repeat (4) @(negedge clk);
        rd(2'd0, d); chk("R5 both edges captures rise", d[7], 1);
        wr(2'd0, 8'h00);
        load_cnt(16'h0999, 1'b0);
        pin_in = 1'b0;
        repeat (4) @(negedge clk);
        rd(2'd0, d); chk("R5 disconnected no flag", d[7], 0);
        rd(2'd1, h); rd(2'd2, l);
        chk("R5 disconnected value kept", {h, l}, 16'h0777);
    endtask

    task automatic t_compare();
        logic [7:0] d;
        do_reset();
        wr(2'd1, 8'h00); wr(2'd2, 8'h05);
        wr(2'd0, 8'h1C);
        chk("R7 oe in compare mode", pin_oe, 1);
        load_cnt(16'h0000, 1'b1);
        wait_cnt(16'd5);
        chk("R7 out low before match", pin_out, 0);
        rd(2'd0, d); chk("R6 no flag before match", d[7], 0);
        @(negedge clk);
        chk("R7 set on match", pin_out, 1);
        rd(2'd0, d); chk("R6 flag on match", d[7], 1);
        wr(2'd0, 8'h18);
        wait_cnt(16'd6);
        chk("R7 clear on match", pin_out, 0);
        wr(2'd0, 8'h14);
        wait_cnt(16'd6);
        chk("R7 toggle on match first", pin_out, 1);
        wait_cnt(16'd6);
        chk("R7 toggle on match second", pin_out, 0);
    endtask

    task automatic t_pwm();
        int bad;
        do_reset();
        wr(2'd1, 8'h00); wr(2'd2, 8'd12);
        wr(2'd0, 8'h1A);
        load_cnt(16'h0000, 1'b1);
        wait_cnt(16'd0);
        bad = 0;
        for (int i = 0; i < 2 * MOD; i++) begin
            if (pin_out !== (cnt <= 16'd12)) bad++;
            @(negedge clk);
        end
        chk("R8 PWM duty from overflow toggle", bad, 0);
        wr(2'd0, 8'h1B);
        bad = 0;
        for (int i = 0; i < 2 * MOD; i++) begin
            if (pin_out !== 1'b1) bad++;
            @(negedge clk);
        end
        chk("R10 force-max holds output high", bad, 0);
        wr(2'd0, 8'h1A);
        wait_cnt(16'd20);
        chk("R10 released force-max follows PWM", pin_out, 0);
    endtask

    task automatic t_priority();
        int bad;
        do_reset();
        wr(2'd1, 8'h00); wr(2'd2, 8'(MOD - 1));
        wr(2'd0, 8'h1A);
        load_cnt(16'h0000, 1'b1);
        bad = 0;
        for (int i = 0; i < 3 * MOD; i++) begin
            if (pin_out !== 1'b0) bad++;
            @(negedge clk);
        end
        chk("R9 clear match beats overflow toggle", bad, 0);
        wr(2'd0, 8'h1E);
        wait_cnt(16'd0);
        bad = 0;
        for (int i = 0; i < 2 * MOD; i++) begin
            if (pin_out !== 1'b1) bad++;
            @(negedge clk);
        end
        chk("R9 set match beats overflow toggle", bad, 0);
    endtask

    task automatic t_buffer();
        logic [7:0] d;
        do_reset();
        wr(2'd1, 8'h00); wr(2'd2, 8'd3);
        wr(2'd0, 8'h24);
        load_cnt(16'h0000, 1'b1);
        wait_cnt(16'd0);
        wait_cnt(16'd10);
        wr(2'd2, 8'd20);
        wr(2'd0, 8'h24);
        wait_cnt(16'd25);
        rd(2'd0, d); chk("R11 buffered value waits for overflow", d[7], 0);
        wait_cnt(16'd25);
        rd(2'd0, d); chk("R11 buffered value active after overflow", d[7], 1);
        wr(2'd0, 8'h14);
        wait_cnt(16'd10);
        wr(2'd2, 8'd22);
        wr(2'd0, 8'h14);
        wait_cnt(16'd25);
        rd(2'd0, d); chk("R11 unbuffered value immediate", d[7], 1);
    endtask

    initial begin
        t_reset();
        t_regs();
        t_capture();
        t_compare();
        t_pwm();
        t_priority();
        t_buffer();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule